// File: doc/BRIEF.md
# Blinking GPIO Port with Input Polarity

This block is a 32-line general-purpose I/O port behind a simple register bus. Software sets each line as input or output, sets the level driven on output lines, can invert the sense of each input line, and can make any output line flash at a fixed hardware rate instead of holding a steady level. The block drives an output-enable and an output-value vector to the pads. It samples the pad inputs through a two-flop synchronizer.

The input-data register returns each synchronized pad level exclusive-ORed with that line's polarity bit. Line n always uses bit n of every register. The flash rate comes from one free-running prescaler whose period is a parameter in clock cycles. Every flashing line shares the same phase, so any group of flashing lines switches together. A write takes effect at the next clock edge. Reads are combinational from the address.

Top module: `gpio_blink_port`

## Requirements
- R1: After reset the level, flash-enable and polarity registers read 0, the direction register reads 0xFFFFFFFF (all inputs), and pad_oe is 0.
- R2: Direction bit n set to 1 makes line n an input (pad_oe[n]=0). Set to 0, it makes line n an output (pad_oe[n]=1).
- R3: The level register sits at byte offset 0x00 and reads back as written. On every line whose flash-enable bit is 0, pad_out[n] equals level bit n.
- R4: The input-data register at offset 0x10 reads as the synchronized pad_in XOR the polarity register (offset 0x0C).
- R5: A change on pad_in first shows in the input-data register after exactly two rising clock edges, not after one.
- R6: A line whose flash-enable bit (offset 0x08) is 1 drives pad_out with a square wave that holds each level for exactly BLINK_CYCLES clock cycles, whatever its level bit holds.
- R7: All lines with flash enabled drive the same value on pad_out in every cycle.
- R8: Writes to offset 0x10 or to any unmapped offset change no register. Reads of unmapped offsets return 0.
- R9: A write with bus_we high at offset 0x00, 0x04 (direction), 0x08 or 0x0C updates the register, the readback and the pads at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| pad_in | input | 32 | Raw pad input levels |
| pad_oe | output | 32 | Per-line output enable |
| pad_out | output | 32 | Per-line output value |

## Verification
The bench builds the port with BLINK_CYCLES set to 5. With that setting, many complete flash periods fit in a short run, and the bench measures the exact spacing between edges of the flashing lines. It also checks that those lines stay in phase while random register writes land around them. At the full 32-line width, random words reach every line's direction, polarity and flash bits together. Directed steps cover the two-edge input latency, writes to the read-only and unmapped offsets, and flashing lines whose level bits are held at both 0 and 1.

// File: rtl/gpio_blink_pkg.sv
package gpio_blink_pkg;
    localparam int unsigned LINES     = 32;
    localparam int unsigned ADDR_W    = 5;
    localparam int unsigned SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] OFS_LEVEL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_DIR   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_FLASH = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_POL   = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_DIN   = 5'h10;

    typedef logic [LINES-1:0] line_vec_t;

    typedef struct packed {
        line_vec_t level;
        line_vec_t dir;
        line_vec_t flash;
        line_vec_t pol;
    } port_regs_t;

    localparam port_regs_t REGS_RESET = '{level: '0, dir: '1, flash: '0, pol: '0};
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = raw_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_flash_timer.sv
module gpio_flash_timer #(
    parameter int unsigned PERIOD = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          phase;
    } timer_t;

    timer_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt == LAST) begin
            t_d.cnt   = '0;
            t_d.phase = ~t_q.phase;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign phase = t_q.phase;
endmodule

// File: rtl/gpio_blink_port.sv
module gpio_blink_port
    import gpio_blink_pkg::*;
#(
    parameter int unsigned BLINK_CYCLES = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    output logic [LINES-1:0]  bus_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_oe,
    output logic [LINES-1:0]  pad_out
);
    port_regs_t regs_d, regs_q;
    line_vec_t  pad_sync;
    line_vec_t  din_view;
    line_vec_t  flash_en;
    logic       flash_phase;

    always_comb begin
        regs_d = regs_q;
        if (bus_we) begin
            case (bus_addr)
                OFS_LEVEL: regs_d.level = bus_wdata;
                OFS_DIR:   regs_d.dir   = bus_wdata;
                OFS_FLASH: regs_d.flash = bus_wdata;
                OFS_POL:   regs_d.pol   = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    gpio_in_sync #(.WIDTH(LINES), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pad_in),
        .sync_out (pad_sync)
    );

    gpio_flash_timer #(.PERIOD(BLINK_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (flash_phase)
    );

    assign din_view = pad_sync ^ regs_q.pol;
    assign flash_en = regs_q.flash;

    for (genvar n = 0; n < LINES; n++) begin : g_line
        assign pad_out[n] = regs_q.flash[n] ? flash_phase : regs_q.level[n];
        assign pad_oe[n]  = ~regs_q.dir[n];
    end

    always_comb begin
        case (bus_addr)
            OFS_LEVEL: bus_rdata = regs_q.level;
            OFS_DIR:   bus_rdata = regs_q.dir;
            OFS_FLASH: bus_rdata = regs_q.flash;
            OFS_POL:   bus_rdata = regs_q.pol;
            OFS_DIN:   bus_rdata = din_view;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_blink_port_chk.sv
module gpio_blink_port_chk
    import gpio_blink_pkg::*;
#(
    parameter int unsigned BLINK_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  pad_in,
    input logic [LINES-1:0]  pad_oe,
    input logic [LINES-1:0]  pad_out,
    input logic [LINES-1:0]  flash_en,
    input logic [LINES-1:0]  pad_sync,
    input logic              flash_phase
);
    localparam int unsigned RW = $clog2(BLINK_CYCLES + 2) + 1;

    logic [1:0]    age_q;
    logic          prev_ph_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_q     <= '0;
            prev_ph_q <= 1'b0;
            run_q     <= '0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            prev_ph_q <= flash_phase;
            if (flash_phase != prev_ph_q) run_q <= RW'(1);
            else if (run_q != '1)         run_q <= run_q + 1'b1;
        end
    end

    p_dir_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == ~$past(bus_wdata)));

    p_level_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_LEVEL) |=>
            ((pad_out & ~flash_en) == ($past(bus_wdata) & ~flash_en)));

    p_sync_depth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pad_sync == $past(pad_in, 2)));

    p_flash_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_phase != prev_ph_q) |-> (run_q == RW'(BLINK_CYCLES)));

    p_flash_inphase_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out & flash_en) == '0) || ((pad_out & flash_en) == flash_en)));

    p_din_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_DIN) |=> $stable(pad_oe));
endmodule

bind gpio_blink_port gpio_blink_port_chk #(.BLINK_CYCLES(BLINK_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .pad_in      (pad_in),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .flash_en    (flash_en),
    .pad_sync    (pad_sync),
    .flash_phase (flash_phase)
);

// File: tb/sim_gpio_blink_port.sv
module sim_gpio_blink_port;
    localparam int CLK_PERIOD = 10;
    localparam int BLINK = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_oe;
    logic [31:0] pad_out;

    int n_checks = 0;
    int n_err = 0;

    logic [31:0] m_level = '0, m_dir = '1, m_flash = '0, m_pol = '0, m_pad = '0;

    gpio_blink_port #(.BLINK_CYCLES(BLINK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_level;
            5'h04:   return m_dir;
            5'h08:   return m_flash;
            5'h0C:   return m_pol;
            5'h10:   return m_pad ^ m_pol;
            default: return 32'h0;
        endcase
    endfunction

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            5'h00: m_level = d;
            5'h04: m_dir = d;
            5'h08: m_flash = d;
            5'h0C: m_pol = d;
            default: ;
        endcase
    endtask

    task automatic rd_check(input string req, input logic [4:0] a);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic check_all(input string tag);
        rd_check({tag, " R3 level"}, 5'h00);
        rd_check({tag, " R9 dir"}, 5'h04);
        rd_check({tag, " R9 flash"}, 5'h08);
        rd_check({tag, " R9 pol"}, 5'h0C);
        rd_check({tag, " R4 din"}, 5'h10);
        rd_check({tag, " R8 unmapped"}, 5'h1C);
        check({tag, " R2 oe"}, pad_oe, ~m_dir);
        check({tag, " R3 out"}, pad_out & ~m_flash, m_level & ~m_flash);
    endtask

    task automatic set_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in = v; m_pad = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic watch_flash(input logic [31:0] mask);
        int last_edge = -1;
        int edges = 0;
        logic prev_v = 1'b0;
        for (int c = 0; c < 8 * BLINK; c++) begin
            @(negedge clk);
            if (c > 0 && (pad_out & mask) != (prev_v ? mask : 32'h0)) begin
                if (last_edge >= 0)
                    check("R6 flash interval", 32'(c - last_edge), 32'(BLINK));
                last_edge = c;
                edges++;
            end
            prev_v = |(pad_out & mask);
            if (((pad_out & mask) != 0) && ((pad_out & mask) != mask))
                check("R7 in phase", pad_out & mask, mask);
            check("R3 steady lines", pad_out & ~m_flash, m_level & ~m_flash);
        end
        check("R6 edges seen", 32'(edges >= 6), 32'h1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'h5eed_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check_all("R1 reset");
        check("R1 oe zero", pad_oe, 32'h0);

        wr(5'h04, 32'h0000_FFFF);
        check_all("R9 after dir write");
        wr(5'h00, 32'hA5A5_5A5A);
        check_all("R9 after level write");

        // R5: latency exactly two edges
        wr(5'h0C, 32'h0F0F_0000);
        @(negedge clk);
        pad_in = 32'h1234_8765;
        @(negedge clk);
        bus_addr = 5'h10; #1;
        check("R5 not after one edge", bus_rdata, 32'h0 ^ m_pol);
        @(negedge clk);
        m_pad = pad_in;
        bus_addr = 5'h10; #1;
        check("R5 after two edges", bus_rdata, m_pad ^ m_pol);

        // R8: writes to read-only and unmapped offsets ignored
        wr(5'h10, 32'hDEAD_BEEF);
        check_all("R8 din write");
        wr(5'h14, 32'hFFFF_FFFF);
        check_all("R8 unmapped write");
        wr(5'h1C, 32'h0);
        check_all("R8 unmapped write 2");

        // R6/R7: flashing lines with level bits both 0 and 1
        wr(5'h00, 32'h0000_00F0);
        wr(5'h08, 32'h0000_0FF0);
        watch_flash(32'h0000_0FF0);
        check_all("R3 with flash");
        wr(5'h08, 32'h8000_0001);
        watch_flash(32'h8000_0001);

        // random mix
        for (int i = 0; i < 60; i++) begin
            logic [4:0] a;
            case ($urandom_range(0, 6))
                0: a = 5'h00; 1: a = 5'h04; 2: a = 5'h08; 3: a = 5'h0C;
                4: a = 5'h10; 5: a = 5'h14; default: a = 5'h18;
            endcase
            wr(a, $urandom());
            check_all("R9 random");
            set_pads($urandom());
            check_all("R4 random");
            if (m_flash != 0 && i % 15 == 0) watch_flash(m_flash);
        end

        report();
    end
endmodule